// File: doc/BRIEF.md
# GHASH Hash-Key Power Table Generator

This block turns a 128-bit hash key into the table of its first six powers in the Galois field GF(2^128), as needed by a GHASH engine that absorbs six blocks per multiply-reduce round. Every entry is kept in bit-reflected form, in which bit `i` of a 128-bit word is the coefficient of `x^i`. The key is first reflected within each byte to give H^1, and all later products are computed in that form.

One digit-serial carry-less multiplier, followed by a two-step fold with the constant 0x87, is shared by five products in a fixed order. The order is H^2 = H·H, H^3 = H^2·H, H^4 = H^2·H^2, H^5 = H^2·H^3 and H^6 = H^3·H^3. Each product reads only entries that are already stored. A start strobe loads a key. A one-hot write strobe marks each entry as it lands, and a single-cycle done flag follows the last one. The whole table is always visible on a flat bus.

Top module: `ghash_pow_gen`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy_o`, `done_o` and `pow_we_o` are 0 and every table entry reads 0.
- R2: Entry 0 (`pow_tbl_o[127:0]`) receives H^1. H^1 is `key_i` reversed within each byte, where byte b occupies `key_i[8b+7:8b]`, so H^1 bit 8b+j equals `key_i[8b+7-j]`. Entry 0 is updated in the cycle after the accepting clock edge.
- R3: Entry k (`pow_tbl_o[128k+127:128k]`, with k from 1 to 5) holds H^(k+1). The product is carry-less multiplication modulo x^128+x^7+x^2+x+1, with bit i meaning the coefficient of x^i.
- R4: `pow_we_o` is one-hot or zero. Bit k is high for exactly one cycle, in the cycle in which entry k first shows its new value. The bits fire in the order 0, 1, 2, 3, 4, 5.
- R5: `done_o` is high for one cycle, together with `pow_we_o[5]`. It rises exactly 5·(128/DIGIT+2) cycles after the cycle that carries `pow_we_o[0]`. `busy_o` is high from the accept edge until that cycle and low in it.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running table, its write order and its timing are unchanged.
- R7: A start in idle after a completed run recomputes all six entries from the new key.
- R8: `key_i` is sampled only at the accepting edge, so later changes to it do not alter the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| key_i | input | 128 | Hash key, byte b in bits [8b+7:8b] |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse when H^6 is stored |
| pow_we_o | output | 6 | One-hot write marker per table entry |
| pow_tbl_o | output | 768 | Flat table, entry k in bits [128k+127:128k] holds H^(k+1) |

## Verification
An operand-select slip, a bad fold or a digit-alignment error first shows up on the entry being written. The fault then spreads into every later power that reads the damaged entry. The bench compares each entry against a chain of plain multiplications by H in the very cycle its write strobe rises. A broken step counter or write index shows as an out-of-order or missing `pow_we_o` bit, or as `done_o` arriving off its fixed cycle count. A start leak during a run shows as entry 0 changing under `busy_o`.

// File: rtl/ghpow_pkg.sv
// Package: shared widths, sequencer states, the product schedule and the
// byte-reflection helper for the hash-key power table generator.
// Assumes a 128-bit field with reduction polynomial x^128+x^7+x^2+x+1.
package ghpow_pkg;

    localparam int GF_W   = 128;
    localparam int NPOW   = 6;
    localparam int IDXW   = $clog2(NPOW);
    localparam int NPROD  = NPOW - 1;
    localparam int STEPW  = $clog2(NPROD + 1);

    typedef logic [GF_W-1:0] gf_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [IDXW-1:0] a_idx;
        logic [IDXW-1:0] b_idx;
    } src_pair_t;

    // Operand entries for each product step (entry k holds H^(k+1)).
    function automatic src_pair_t sched_src(input logic [STEPW-1:0] step);
        src_pair_t p;
        case (step)
            3'd0:    begin p.a_idx = 3'd0; p.b_idx = 3'd0; end
            3'd1:    begin p.a_idx = 3'd1; p.b_idx = 3'd0; end
            3'd2:    begin p.a_idx = 3'd1; p.b_idx = 3'd1; end
            3'd3:    begin p.a_idx = 3'd1; p.b_idx = 3'd2; end
            default: begin p.a_idx = 3'd2; p.b_idx = 3'd2; end
        endcase
        return p;
    endfunction

    // Reverse the bit order inside every byte of a 128-bit word.
    function automatic gf_t refl_bytes(input gf_t k);
        gf_t r;
        for (int b = 0; b < GF_W/8; b++) begin
            for (int j = 0; j < 8; j++) begin
                r[8*b + j] = k[8*b + 7 - j];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_dsmul.sv
// Module: digit-serial carry-less multiplier. Produces the full 255-bit
// unreduced product of a and b, taking DIGIT bits of b per clock, low
// digits first. Assumes DIGIT divides 128. go_i is taken only while idle;
// rdy_o is high for one cycle when the product is complete and it is
// assumed to be consumed in that cycle.
module gf_dsmul
    import ghpow_pkg::*;
#(
    parameter int DIGIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  gf_t               a_i,
    input  gf_t               b_i,
    output logic              rdy_o,
    output logic [2*GF_W-1:0] prod_o
);

    localparam int NSTEP = GF_W / DIGIT;
    localparam int CW    = $clog2(NSTEP + 1);
    localparam int PW    = 2 * GF_W;

    logic [PW-1:0]   a_sh;
    gf_t             b_sh;
    logic [PW-1:0]   acc;
    logic [CW-1:0]   cnt;
    logic            act;
    logic [PW-1:0]   term [DIGIT];
    logic [PW-1:0]   part;

    // One shifted copy of a per digit bit, gated by that bit of b.
    for (genvar j = 0; j < DIGIT; j++) begin : g_term
        assign term[j] = b_sh[j] ? (a_sh << j) : '0;
    end

    // XOR the gated copies into the partial product of this digit.
    always_comb begin
        part = '0;
        for (int j = 0; j < DIGIT; j++) begin
            part = part ^ term[j];
        end
    end

    // Load operands, then accumulate one digit per cycle until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_sh <= '0;
            acc  <= '0;
            cnt  <= '0;
            act  <= 1'b0;
        end else if (!act) begin
            if (go_i) begin
                a_sh <= {{GF_W{1'b0}}, a_i};
                b_sh <= b_i;
                acc  <= '0;
                cnt  <= CW'(NSTEP);
                act  <= 1'b1;
            end
        end else if (cnt != '0) begin
            acc  <= acc ^ part;
            a_sh <= a_sh << DIGIT;
            b_sh <= b_sh >> DIGIT;
            cnt  <= cnt - 1'b1;
        end else begin
            act  <= 1'b0;
        end
    end

    // Result is valid in the cycle after the last digit is absorbed.
    assign rdy_o  = act && (cnt == '0);
    assign prod_o = acc;

endmodule

// File: rtl/gf_fold.sv
// Module: reduces a 256-bit carry-less product modulo x^128+x^7+x^2+x+1
// with two folds by the constant 0x87. The first fold multiplies the high
// half and leaves at most 7 overflow bits; the second folds those into
// the low 14 bits, after which nothing overflows. Purely combinational.
module gf_fold
    import ghpow_pkg::*;
(
    input  logic [2*GF_W-1:0] prod_i,
    output gf_t               res_o
);

    localparam int T1W = GF_W + 7;
    localparam int OVW = 7;
    localparam int T2W = OVW + 7;

    gf_t              hi;
    gf_t              lo;
    logic [T1W-1:0]   t1;
    logic [OVW-1:0]   ov;
    logic [T2W-1:0]   t2;

    assign hi = prod_i[2*GF_W-1:GF_W];
    assign lo = prod_i[GF_W-1:0];

    // First fold: high half times (x^7 + x^2 + x + 1).
    always_comb begin
        t1 = {7'b0, hi} ^ {6'b0, hi, 1'b0} ^ {5'b0, hi, 2'b0} ^ {hi, 7'b0};
    end

    assign ov = t1[T1W-1:GF_W];

    // Second fold: the few overflow bits times the same constant.
    always_comb begin
        t2 = {7'b0, ov} ^ {6'b0, ov, 1'b0} ^ {5'b0, ov, 2'b0} ^ {ov, 7'b0};
    end

    // Combine both folds with the untouched low half.
    assign res_o = lo ^ t1[GF_W-1:0] ^ {{(GF_W-T2W){1'b0}}, t2};

endmodule

// File: rtl/ghpow_seq.sv
// Module: control sequencer. Accepts a start in idle, then runs the five
// products in schedule order: issue the operands, wait for the multiplier,
// write the folded result, advance. Assumes the multiplier ignores go_i
// while busy and presents rdy_o for exactly one cycle per product.
module ghpow_seq
    import ghpow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mul_rdy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cap_o,
    output logic             mul_go_o,
    output logic [IDXW-1:0]  a_idx_o,
    output logic [IDXW-1:0]  b_idx_o,
    output logic             wr_o,
    output logic [IDXW-1:0]  wr_idx_o
);

    localparam logic [STEPW-1:0] LAST_STEP = STEPW'(NPROD - 1);

    sq_state_e         state;
    logic [STEPW-1:0]  step;
    logic              done_q;
    src_pair_t         src;

    // Next-state and step bookkeeping for the product schedule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            step   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        state <= SQ_ISSUE;
                        step  <= '0;
                    end
                end
                SQ_ISSUE: begin
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (mul_rdy_i) begin
                        if (step == LAST_STEP) begin
                            state  <= SQ_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= SQ_ISSUE;
                            step  <= step + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Operand entries for the current step.
    always_comb begin
        src = sched_src(step);
    end

    assign busy_o   = (state != SQ_IDLE);
    assign done_o   = done_q;
    assign cap_o    = (state == SQ_IDLE) && start_i;
    assign mul_go_o = (state == SQ_ISSUE);
    assign a_idx_o  = src.a_idx;
    assign b_idx_o  = src.b_idx;
    assign wr_o     = (state == SQ_WAIT) && mul_rdy_i;
    assign wr_idx_o = IDXW'(step) + 1'b1;

endmodule

// File: rtl/ghpow_store.sv
// Module: six-entry power table. Entry 0 takes the byte-reflected key on a
// capture; entries 1..5 take folded products. Two read ports feed the
// multiplier, the whole table is driven flat, and a registered one-hot
// marker shows which entry changed at the last edge. Assumes capture and
// product writes never coincide.
module ghpow_store
    import ghpow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  gf_t              key_i,
    input  logic             wr_i,
    input  logic [IDXW-1:0]  wr_idx_i,
    input  gf_t              wr_data_i,
    input  logic [IDXW-1:0]  rd_a_idx_i,
    input  logic [IDXW-1:0]  rd_b_idx_i,
    output gf_t              rd_a_o,
    output gf_t              rd_b_o,
    output logic [NPOW-1:0]  we_o,
    output logic [NPOW*GF_W-1:0] tbl_o
);

    gf_t              ent [NPOW];
    logic [NPOW-1:0]  hit;

    // Per-entry write decode: entry 0 on capture, others by index.
    always_comb begin
        hit = '0;
        if (cap_i) begin
            hit[0] = 1'b1;
        end else if (wr_i) begin
            hit = NPOW'(1) << wr_idx_i;
        end
    end

    // Entry 0 register holds H^1 in reflected form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent[0] <= '0;
        end else if (hit[0]) begin
            ent[0] <= refl_bytes(key_i);
        end
    end

    // Product entries, one register each.
    for (genvar k = 1; k < NPOW; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[k] <= '0;
            end else if (hit[k]) begin
                ent[k] <= wr_data_i;
            end
        end
    end

    // Registered marker of the entry written at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o <= '0;
        end else begin
            we_o <= hit;
        end
    end

    // Flatten the table onto the output bus.
    for (genvar k = 0; k < NPOW; k++) begin : g_flat
        assign tbl_o[GF_W*k +: GF_W] = ent[k];
    end

    assign rd_a_o = ent[rd_a_idx_i];
    assign rd_b_o = ent[rd_b_idx_i];

endmodule

// File: rtl/ghash_pow_gen.sv
// Module: top of the hash-key power table generator. Joins the sequencer,
// the table, the digit-serial multiplier and the two-step fold. One run
// takes 5*(128/DIGIT + 2) cycles after the accepting edge.
module ghash_pow_gen
    import ghpow_pkg::*;
#(
    parameter int DIGIT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [127:0]         key_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [5:0]           pow_we_o,
    output logic [767:0]         pow_tbl_o
);

    logic              cap;
    logic              mul_go;
    logic              mul_rdy;
    logic [IDXW-1:0]   a_idx;
    logic [IDXW-1:0]   b_idx;
    logic              wr;
    logic [IDXW-1:0]   wr_idx;
    gf_t               op_a;
    gf_t               op_b;
    logic [2*GF_W-1:0] prod;
    gf_t               folded;

    ghpow_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mul_rdy_i (mul_rdy),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .cap_o     (cap),
        .mul_go_o  (mul_go),
        .a_idx_o   (a_idx),
        .b_idx_o   (b_idx),
        .wr_o      (wr),
        .wr_idx_o  (wr_idx)
    );

    ghpow_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .key_i      (key_i),
        .wr_i       (wr),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (folded),
        .rd_a_idx_i (a_idx),
        .rd_b_idx_i (b_idx),
        .rd_a_o     (op_a),
        .rd_b_o     (op_b),
        .we_o       (pow_we_o),
        .tbl_o      (pow_tbl_o)
    );

    gf_dsmul #(.DIGIT(DIGIT)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go),
        .a_i    (op_a),
        .b_i    (op_b),
        .rdy_o  (mul_rdy),
        .prod_o (prod)
    );

    gf_fold u_fold (
        .prod_i (prod),
        .res_o  (folded)
    );

endmodule

// File: rtl/ghpow_chk.sv
// Module: protocol checker for the power table generator, bound to the top.
// Tracks the last write marker so that write order can be checked without
// long look-back windows.
module ghpow_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [5:0]   pow_we_o,
    input logic [127:0] tbl0_i
);

    logic [5:0] last_we;

    // Remember the most recent non-zero write marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_we <= '0;
        end else if (pow_we_o != '0) begin
            last_we <= pow_we_o;
        end
    end

    // R4
    we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pow_we_o));

    // R4
    we_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pow_we_o != 6'd0 && !pow_we_o[0]) |-> (pow_we_o == (last_we << 1)));

    // R5
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pow_we_o[5] && !busy_o));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R6
    h1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(tbl0_i));

    // R2
    cap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pow_we_o[0] |-> ($past(start_i) && !$past(busy_o)));

endmodule

bind ghash_pow_gen ghpow_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pow_we_o (pow_we_o),
    .tbl0_i   (pow_tbl_o[127:0])
);

// File: tb/ghash_pow_gen_test.sv
`timescale 1ns/1ps
module ghash_pow_gen_test;

    localparam int DIGIT = 8;
    localparam int LAT   = 5 * (128 / DIGIT + 2);
    localparam int WD_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [5:0]   pow_we_o;
    logic [767:0] pow_tbl_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ghash_pow_gen #(.DIGIT(DIGIT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .key_i     (key_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pow_we_o  (pow_we_o),
        .pow_tbl_o (pow_tbl_o)
    );

    // Field product with bit i = coefficient of x^i, reduced bit by bit.
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] z = '0;
        logic [127:0] v = a;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) z = z ^ v;
            v = (v << 1) ^ (v[127] ? 128'h87 : 128'h0);
        end
        return z;
    endfunction

    function automatic logic [127:0] ref_refl(input logic [127:0] k);
        logic [127:0] r;
        for (int b = 0; b < 16; b++)
            for (int j = 0; j < 8; j++)
                r[8*b + j] = k[8*b + 7 - j];
        return r;
    endfunction

    function automatic logic [127:0] entry(input int k);
        return pow_tbl_o[128*k +: 128];
    endfunction

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full run; optionally pokes start mid-run (R6) or changes the key (R8).
    task automatic run_key(input logic [127:0] key, input bit poke_busy, input bit poke_key, input string tag);
        logic [127:0] h [6];
        int nxt;
        int cnt;
        bit fin;
        h[0] = ref_refl(key);
        for (int k = 1; k < 6; k++) h[k] = ref_mul(h[k-1], h[0]);
        @(negedge clk);
        start_i = 1'b1;
        key_i   = key;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        if (poke_key) key_i = ~key;
        chk(pow_we_o == 6'b000001, "R4 first marker", 128'(pow_we_o), 128'h1);
        chk(busy_o == 1'b1, "R5 busy after accept", 128'(busy_o), 128'h1);
        chk(entry(0) == h[0], "R2 reflected key", entry(0), h[0]);
        nxt = 1;
        cnt = 0;
        fin = 1'b0;
        while (!fin && cnt < 400) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            start_i = 1'b0;
            if (pow_we_o != 6'd0) begin
                chk(nxt < 6 && pow_we_o == (6'd1 << nxt), "R4 write order", 128'(pow_we_o), 128'(6'd1 << nxt));
                if (nxt < 6) begin
                    chk(entry(nxt) == h[nxt], "R3 entry at write", entry(nxt), h[nxt]);
                    nxt++;
                end
            end
            if (done_o) fin = 1'b1;
            if (poke_busy && (cnt == 10 || cnt == 47)) begin
                start_i = 1'b1;
                key_i   = {$urandom, $urandom, $urandom, $urandom};
            end
        end
        start_i = 1'b0;
        chk(fin && cnt == LAT, "R5 done latency", 128'(cnt), 128'(LAT));
        chk(busy_o == 1'b0, "R5 busy low at done", 128'(busy_o), 128'h0);
        chk(nxt == 6, "R4 all markers seen", 128'(nxt), 128'd6);
        for (int k = 0; k < 6; k++)
            chk(entry(k) == h[k], tag, entry(k), h[k]);
        @(negedge clk);
        chk(done_o == 1'b0, "R5 done single pulse", 128'(done_o), 128'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", WD_CYCLES);
        report();
        $finish;
    end

    initial begin
        int seed_tap;
        logic [127:0] rk;
        seed_tap = $urandom(32'h00C0FFEE);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(busy_o == 1'b0 && done_o == 1'b0 && pow_we_o == 6'd0, "R1 ctrl in reset",
            128'({busy_o, done_o, pow_we_o}), 128'h0);
        chk(pow_tbl_o == '0, "R1 table in reset", pow_tbl_o[127:0], 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && pow_we_o == 6'd0, "R1 idle after reset", 128'({busy_o, pow_we_o}), 128'h0);

        // Directed corners: zero, unit element, all ones, top coefficient.
        run_key(128'h0, 1'b0, 1'b0, "R3 zero key");
        run_key(128'h80, 1'b0, 1'b0, "R7 unit key");
        run_key({128{1'b1}}, 1'b0, 1'b0, "R3 all-ones key");
        run_key(128'h01 << 120, 1'b0, 1'b0, "R3 x^127 key");

        // Random keys, with mid-run start pokes and key changes.
        for (int n = 0; n < 6; n++) begin
            rk = {$urandom, $urandom, $urandom, $urandom};
            run_key(rk, 1'b0, 1'b0, "R7 random key");
        end
        rk = {$urandom, $urandom, $urandom, $urandom};
        run_key(rk, 1'b1, 1'b0, "R6 start while busy");
        rk = {$urandom, $urandom, $urandom, $urandom};
        run_key(rk, 1'b0, 1'b1, "R8 key changed after accept");
        rk = {$urandom, $urandom, $urandom, $urandom};
        run_key(rk, 1'b1, 1'b1, "R6 R8 combined");

        report();
        $finish;
    end

endmodule